// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a register-programmed master for the two-wire PHY management bus. Software writes one 32-bit word that already holds a complete Clause 22 frame: start code, opcode, PHY address, register address, turnaround and data. The block sends a run of ones as a preamble and then shifts the 32 frame bits out, most significant bit first, on a divided management clock. It drives MDIO on the falling edge of MDC and samples it on the rising edge.

On a read frame the block stops driving the line partway through the turnaround. It then shifts the 16 data bits returned by the PHY into the low half of the frame register. When the frame ends, a sticky event flag is set. Software clears the flag by writing a one to it.

The register port has four word addresses:

| Address | Register | Contents |
|---|---|---|
| 0 | frame | The frame word. Writing it starts a transaction. |
| 1 | event | Completion flag in bit 0. |
| 2 | control | Management-mode enable in bit 0. |
| 3 | speed | 6-bit clock divider in bits 6:1. |

Software chooses the divider as the ceiling of the system clock divided by 5 MHz. This keeps MDC at or below 2.5 MHz.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, all four registers read zero, MDC is low and the MDIO output enable is low.
- R2: A transaction puts 32 ones on MDIO, followed by frame bits 31 down to 0. One bit is sent per MDC period, and each bit is valid at the MDC rising edge.
- R3: With a divider value D, MDC stays low for D clocks and high for D clocks, so its period is 2·D system clocks.
- R4: For a read frame (bits 29:28 = 10), the output enable is low from frame bit 16 (the second turnaround bit) through the last data bit. For any other opcode, the output enable stays high for all 64 bits. Whenever the output enable is low, MDIO out is 0.
- R5: On a read, the bits sampled at the last 16 MDC rising edges replace frame bits 15:0, first bit in bit 15. Bits 31:16 keep their written value.
- R6: The event flag (address 1, bit 0) becomes set exactly 128·D clocks after the clock edge that accepted the frame write. At that point MDC is low and the output enable is low.
- R7: Writing 1 to event bit 0 clears the flag. Writing 0 leaves it unchanged.
- R8: A frame write that arrives while a transaction is running is ignored. The running frame continues unchanged.
- R9: A frame write while control bit 0 is clear is ignored: no MDC edges occur and the frame register keeps its value.
- R10: With a divider value of 0, an accepted frame stalls with MDC low and no completion. Writing a nonzero divider resumes the frame.
- R11: The speed register stores only bits 6:1, and its other bits read as zero. The control register stores only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
A bit counter that is off by one, or a wrong turnaround boundary, shows up at the first MDC rising edge of the affected bit. The captured 64-bit MDIO and output-enable streams then differ from the computed ones within that same frame. A divider or phase error changes the spacing of MDC rising edges and moves the completion flag away from 128·D clocks, so it is visible on the first frame. Errors in the read path or in register handling appear at the next read of the frame or event register.

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
  parameter int PRE_BITS = 32,
  parameter int DIV_W    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int NBITS = PRE_BITS + 32;
  localparam int IW    = $clog2(NBITS);
  localparam logic [1:0] A_FRAME = 2'd0, A_EVT = 2'd1, A_CTRL = 2'd2, A_SPD = 2'd3;

  logic [31:0]      frame;
  logic             evt, en, busy;
  logic [DIV_W-1:0] div, cnt;
  logic [IW-1:0]    idx;
  logic [4:0]       fpos;

  assign fpos = 5'(idx - IW'(PRE_BITS));

  wire in_frame = idx >= IW'(PRE_BITS);
  wire is_rd    = frame[29:28] == 2'b10;
  wire rd_data  = is_rd && in_frame && fpos >= 5'd16;
  wire released = is_rd && in_frame && fpos >= 5'd15;
  wire bitval   = in_frame ? frame[5'd31 - fpos] : 1'b1;
  wire tick     = busy && div != '0 && cnt >= div - 1'b1;
  wire last     = idx == IW'(NBITS - 1);
  wire start    = reg_wr && reg_addr == A_FRAME && !busy && en;

  assign mdio_oe = busy && !released;
  assign mdio_o  = mdio_oe && bitval;

  always_comb begin
    case (reg_addr)
      A_FRAME: reg_rdata = frame;
      A_EVT:   reg_rdata = {31'b0, evt};
      A_CTRL:  reg_rdata = {31'b0, en};
      default: reg_rdata = {{(31-DIV_W){1'b0}}, div, 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame <= '0;
      evt   <= 1'b0;
      en    <= 1'b0;
      busy  <= 1'b0;
      div   <= '0;
      cnt   <= '0;
      idx   <= '0;
      mdc   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) en <= reg_wdata[0];
      if (reg_wr && reg_addr == A_SPD)  div <= reg_wdata[DIV_W:1];
      if (reg_wr && reg_addr == A_EVT && reg_wdata[0]) evt <= 1'b0;
      if (start) begin
        frame <= reg_wdata;
        busy  <= 1'b1;
        idx   <= '0;
        cnt   <= '0;
        mdc   <= 1'b0;
      end else if (busy && div != '0) begin
        if (!tick) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          mdc <= !mdc;
          if (!mdc) begin
            if (rd_data) frame[15:0] <= {frame[14:0], mdio_i};
          end else if (last) begin
            busy <= 1'b0;
            evt  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

module mdio_frame_master_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             mdc,
  input logic             busy,
  input logic             evt,
  input logic [DIV_W-1:0] div,
  input logic [15:0]      frame_hi
);
  AST_DONE_SETS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> evt); // R6
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R6
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !(reg_wr && reg_addr == 2'd1 && reg_wdata[0])) |=> evt); // R7
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 2'd0) |=> $stable(frame_hi)); // R8
  AST_ZERO_DIV_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0) |=> $stable(mdc)); // R10
  AST_NO_RISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !$rose(mdc)); // R3
endmodule

bind mdio_frame_master mdio_frame_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mdc(mdc), .busy(busy), .evt(evt), .div(div),
  .frame_hi(frame[31:16])
);

// File: tb/mdio_frame_master_bench.sv
module mdio_frame_master_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdc, mdio_i, mdio_o, mdio_oe;

  int     n_cmp = 0, n_bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  logic [15:0] resp = 16'h0;
  logic        rc_clr = 1'b0;
  int          rc = 0;
  logic [63:0] cap_o = '0, cap_oe = '0;
  longint      t0 = 0, t1 = 0;

  mdio_frame_master u_mdio_frame_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always @(posedge mdc or posedge rc_clr) begin
    if (rc_clr) begin
      rc = 0; cap_o = '0; cap_oe = '0;
    end else begin
      if (rc < 64) begin
        cap_o[63-rc]  = mdio_o;
        cap_oe[63-rc] = mdio_oe;
      end
      if (rc == 0) t0 = cyc;
      if (rc == 1) t1 = cyc;
      rc++;
    end
  end

  assign mdio_i = (rc >= 48 && rc < 64) ? resp[63-rc] : 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic clear_caps();
    rc_clr = 1'b1; #1 rc_clr = 1'b0;
  endtask

  task automatic wait_evt(input bit inj, input logic [31:0] inj_v, output int k);
    reg_addr = 2'd1; k = 0;
    while (k < 20000) begin
      @(negedge clk); k++;
      if (inj && k == 20) begin
        reg_addr = 2'd0; reg_wr = 1'b1; reg_wdata = inj_v;
        continue;
      end
      if (inj && k == 21) begin reg_wr = 1'b0; reg_addr = 2'd1; end
      #1 if (reg_rdata[0]) break;
    end
  endtask

  function automatic logic [63:0] exp_oe(input logic [31:0] f);
    return (f[29:28] == 2'b10) ? 64'hFFFF_FFFF_FFFE_0000 : '1;
  endfunction

  task automatic run_frame(input logic [31:0] f, input int d, input logic [15:0] r,
                           input bit inj, input logic [31:0] inj_v);
    int k; logic [31:0] v; logic [63:0] eo;
    resp = r;
    clear_caps();
    wr(2'd0, f);
    wait_evt(inj, inj_v, k);
    eo = exp_oe(f);
    chk("R6 completion cycles", 64'(k), 64'(128*d));
    chk("R2 mdio bit stream", cap_o, {32'hFFFF_FFFF, f} & eo);
    chk("R4 output enable pattern", cap_oe, eo);
    chk("R3 mdc period", 64'(t1 - t0), 64'(2*d));
    #1 chk("R6 idle outputs", {62'b0, mdc, mdio_oe}, 64'b0);
    rd(2'd0, v);
    chk(inj ? "R8 frame after ignored write" : "R5 frame readback", 64'(v),
        64'((f[29:28] == 2'b10) ? {f[31:16], r} : f));
    wr(2'd1, 32'h0); rd(2'd1, v); chk("R7 zero write keeps event", 64'(v), 64'd1);
    wr(2'd1, 32'h1); rd(2'd1, v); chk("R7 one write clears event", 64'(v), 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k;
    int divs [4] = '{1, 2, 3, 7};
    rst_n = 1'b0; reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reset register", 64'(v), 64'd0);
    end
    chk("R1 reset pins", {62'b0, mdc, mdio_oe}, 64'd0);

    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("R11 speed field mask", 64'(v), 64'h7E);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); chk("R11 control field mask", 64'(v), 64'h1);
    wr(2'd2, 32'h0);
    wr(2'd1, 32'h1); rd(2'd1, v); chk("R7 clear when already clear", 64'(v), 64'd0);

    wr(2'd3, 32'(2 << 1));
    clear_caps();
    wr(2'd0, 32'h6AAA_5555);
    repeat (100) @(negedge clk);
    chk("R9 no mdc edges when disabled", 64'(rc), 64'd0);
    rd(2'd0, v); chk("R9 frame unchanged when disabled", 64'(v), 64'd0);
    rd(2'd1, v); chk("R9 no event when disabled", 64'(v), 64'd0);

    wr(2'd3, 32'h0);
    wr(2'd2, 32'h1);
    resp = 16'h0;
    clear_caps();
    wr(2'd0, 32'h5A4A_BEEF);
    repeat (200) @(negedge clk);
    chk("R10 no mdc edges at divider zero", 64'(rc), 64'd0);
    chk("R10 mdc low at divider zero", {63'b0, mdc}, 64'd0);
    rd(2'd1, v); chk("R10 no completion at divider zero", 64'(v), 64'd0);
    wr(2'd3, 32'(2 << 1));
    wait_evt(1'b0, 32'h0, k);
    chk("R10 resumed stream", cap_o, {32'hFFFF_FFFF, 32'h5A4A_BEEF});
    wr(2'd1, 32'h1);

    for (int i = 0; i < 4; i++) begin
      wr(2'd3, 32'(divs[i] << 1));
      for (int op = 0; op < 2; op++) begin
        logic [4:0]  phy, rg;
        logic [15:0] dat, rsp;
        logic [31:0] f;
        phy = 5'(i * 7 + op * 3 + 1);
        rg  = 5'(i * 5 + op * 11);
        dat = 16'(16'h1357 * (i + 1) ^ (op * 16'hA5A5));
        rsp = 16'(16'hC3A0 + i * 257 + op * 4660);
        f = {2'b01, (op == 1) ? 2'b10 : 2'b01, phy, rg, 2'b10, dat};
        run_frame(f, divs[i], rsp, (i == 2), 32'h5FFF_0000);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule